// File: doc/BRIEF.md
# Oscillator Settle Wait Timer

This block measures the settling interval of the high-speed oscillator when a low-power stop state ends. Software picks one of five power-of-two wait lengths through an 8-bit select register. The block takes that choice at the moment the stop state is released. From the next high-speed clock edge it counts edges until the chosen length is reached. It then raises a ready level to the clock switch logic and emits a one-cycle completion pulse.

A read-only status register has one bit per wait threshold. Software uses it to follow the progress of the wait when the CPU is clocked from the ring oscillator. In that case the ready level does not hold the CPU back. The counter stops at the chosen length, so status bits for longer thresholds stay clear. Stop entry clears the status. Release pulses that arrive outside the stop state are ignored.

Top module: `osc_settle_timer`

## Requirements
- R1: Address 0 reads as `{5'b0, code}`, where code is the 3-bit wait select. Reset loads code 3'b101, so the register reads 8'h05.
- R2: A write to address 0 takes only bits 2:0 of the write data. A write whose code is 3'b000, 3'b110 or 3'b111 is ignored and leaves the previous code in place.
- R3: At release the code selects the wait length T: 3'b001 gives 2^11, 3'b010 gives 2^13, 3'b011 gives 2^14, 3'b100 gives 2^15 and 3'b101 gives 2^16 clock edges. `settle_pulse` is high for exactly the one cycle after the T-th rising edge that follows the release edge.
- R4: The count restarts from zero at each accepted release. The code is latched at that edge, so writes made during the wait leave its length unchanged.
- R5: Address 1 reads as `{3'b0, status}`. Status bit 0 stands for 2^11, bit 1 for 2^13, bit 2 for 2^14, bit 3 for 2^15 and bit 4 for 2^16. A bit sets on the edge at which the count reaches its threshold. Writes to address 1 have no effect.
- R6: After a wait completes, status bits whose threshold exceeds the chosen length stay clear until the next stop entry.
- R7: A `stop_enter` pulse clears all status bits, drops `clk_ready` from the next cycle, and holds the count at zero until a release arrives. This applies in every state, and stop entry wins over a simultaneous release.
- R8: If `cpu_on_hs` is high at the release edge, `clk_ready` stays low through the wait and rises in the same cycle as `settle_pulse`.
- R9: If `cpu_on_hs` is low at the release edge, `clk_ready` is high from the cycle after the release, while the status bits still advance.
- R10: After reset, before any stop entry, status reads 8'h1F and `clk_ready` is high.
- R11: A `stop_release` pulse outside the stop state does nothing. No pulse follows, and the status is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = wait select, 1 = status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| stop_enter | input | 1 | One-cycle pulse when the stop state begins |
| stop_release | input | 1 | One-cycle pulse when the stop state ends |
| cpu_on_hs | input | 1 | High when the CPU runs from the high-speed clock |
| clk_ready | output | 1 | Clock may be released to the CPU |
| settle_pulse | output | 1 | One-cycle pulse when the wait completes |

## Verification
Register writes show on `reg_rdata` in the cycle after the write edge, because the read path itself adds no latency. Status bits and `clk_ready` change one cycle after the edge that sets or clears them. The completion pulse appears after exactly T rising edges counted from the release edge. A behavioural model advances on the same rising edges from the same inputs. It is compared with every output at the falling edge, midway between input changes. Directed timing checks count rising edges from the release edge up to the falling edge at which the pulse is first seen, so the expected value is T itself.

// File: rtl/ost_pkg.sv
package ost_pkg;

    localparam int NUM_THR = 5;
    localparam int CODE_W  = 3;
    localparam int CNT_W   = 17;
    localparam int DATA_W  = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STOP = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } ost_state_e;

    typedef struct packed {
        ost_state_e           state;
        logic [CNT_W-1:0]     cnt;
        logic [CNT_W-1:0]     target;
        logic                 hs;
        logic [NUM_THR-1:0]   status;
        logic                 pulse;
    } ost_ctr_t;

    // exponent of threshold idx; index 0 is the shortest wait
    function automatic int thr_exp(input int idx);
        case (idx)
            0:       return 11;
            1:       return 13;
            2:       return 14;
            3:       return 15;
            default: return 16;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] thr_val(input int idx);
        return CNT_W'(1) << thr_exp(idx);
    endfunction

    function automatic logic code_legal(input logic [CODE_W-1:0] c);
        return (c >= CODE_W'(1)) && (c <= CODE_W'(NUM_THR));
    endfunction

endpackage

// File: rtl/ost_sel_reg.sv
module ost_sel_reg
    import ost_pkg::*;
#(
    parameter int               SEL_W      = CODE_W,
    parameter logic [SEL_W-1:0] RESET_CODE = SEL_W'(5)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_code,
    output logic [SEL_W-1:0] sel_code
);

    logic [SEL_W-1:0] sel_d;
    logic [SEL_W-1:0] sel_q;

    always_comb begin
        sel_d = sel_q;
        if (wr_en && code_legal(CODE_W'(wr_code))) begin
            sel_d = wr_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= RESET_CODE;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign sel_code = sel_q;

    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        code_legal(CODE_W'(sel_q))); // R2

    AST_BAD_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !code_legal(CODE_W'(wr_code))) |=> $stable(sel_q)); // R2

endmodule

// File: rtl/ost_counter.sv
module ost_counter
    import ost_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stop_enter,
    input  logic                stop_release,
    input  logic                cpu_on_hs,
    input  logic [CODE_W-1:0]   sel_code,
    output logic                clk_ready,
    output logic                settle_pulse,
    output logic [NUM_THR-1:0]  status
);

    ost_ctr_t ctr_d;
    ost_ctr_t ctr_q;

    always_comb begin
        ctr_d       = ctr_q;
        ctr_d.pulse = 1'b0;
        case (ctr_q.state)
            ST_STOP: begin
                if (stop_release) begin
                    ctr_d.state  = ST_WAIT;
                    ctr_d.cnt    = '0;
                    ctr_d.target = thr_val(int'(sel_code) - 1);
                    ctr_d.hs     = cpu_on_hs;
                end
            end
            ST_WAIT: begin
                ctr_d.cnt = ctr_q.cnt + CNT_W'(1);
                for (int k = 0; k < NUM_THR; k++) begin
                    if (ctr_d.cnt >= thr_val(k)) begin
                        ctr_d.status[k] = 1'b1;
                    end
                end
                if (ctr_d.cnt == ctr_q.target) begin
                    ctr_d.state = ST_DONE;
                    ctr_d.pulse = 1'b1;
                end
            end
            default: begin
                // idle and done hold; releases are ignored here
            end
        endcase
        if (stop_enter) begin
            ctr_d.state  = ST_STOP;
            ctr_d.cnt    = '0;
            ctr_d.status = '0;
            ctr_d.pulse  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_q.state  <= ST_IDLE;
            ctr_q.cnt    <= '0;
            ctr_q.target <= '0;
            ctr_q.hs     <= 1'b1;
            ctr_q.status <= '1;
            ctr_q.pulse  <= 1'b0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign clk_ready    = (ctr_q.state == ST_IDLE) || (ctr_q.state == ST_DONE) ||
                          ((ctr_q.state == ST_WAIT) && !ctr_q.hs);
    assign settle_pulse = ctr_q.pulse;
    assign status       = ctr_q.status;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        settle_pulse |=> !settle_pulse); // R3

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_enter |=> ((status == '0) && !clk_ready)); // R7

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_q.state != ST_IDLE) |-> (ctr_q.cnt <= ctr_q.target)); // R4

    AST_STATUS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_enter |=> ((status & $past(status)) == $past(status))); // R5

    AST_PULSE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        settle_pulse |-> clk_ready); // R8

endmodule

// File: rtl/ost_readback.sv
module ost_readback
    import ost_pkg::*;
#(
    parameter int RD_W = DATA_W
) (
    input  logic               addr,
    input  logic [CODE_W-1:0]  sel_code,
    input  logic [NUM_THR-1:0] status,
    output logic [RD_W-1:0]    rdata
);

    always_comb begin
        rdata = '0;
        if (addr) begin
            rdata[NUM_THR-1:0] = status;
        end else begin
            rdata[CODE_W-1:0] = sel_code;
        end
    end

endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer
    import ost_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              stop_enter,
    input  logic              stop_release,
    input  logic              cpu_on_hs,
    output logic              clk_ready,
    output logic              settle_pulse
);

    logic [CODE_W-1:0]  sel_code;
    logic [NUM_THR-1:0] status;

    ost_sel_reg #(
        .SEL_W      (CODE_W),
        .RESET_CODE (CODE_W'(5))
    ) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr && !reg_addr),
        .wr_code  (reg_wdata[CODE_W-1:0]),
        .sel_code (sel_code)
    );

    ost_counter u_ctr (
        .clk          (clk),
        .rst_n        (rst_n),
        .stop_enter   (stop_enter),
        .stop_release (stop_release),
        .cpu_on_hs    (cpu_on_hs),
        .sel_code     (sel_code),
        .clk_ready    (clk_ready),
        .settle_pulse (settle_pulse),
        .status       (status)
    );

    ost_readback #(
        .RD_W (DATA_W)
    ) u_rd (
        .addr     (reg_addr),
        .sel_code (sel_code),
        .status   (status),
        .rdata    (reg_rdata)
    );

endmodule

// File: tb/osc_settle_timer_tb.sv
`timescale 1ns/1ps
module osc_settle_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       stop_enter = 1'b0;
    logic       stop_release = 1'b0;
    logic       cpu_on_hs = 1'b1;
    logic       clk_ready;
    logic       settle_pulse;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    osc_settle_timer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stop_enter(stop_enter),
        .stop_release(stop_release), .cpu_on_hs(cpu_on_hs),
        .clk_ready(clk_ready), .settle_pulse(settle_pulse)
    );

    // ---------------- behavioural reference ----------------
    int m_mode;      // 0 idle, 1 stopped, 2 waiting, 3 finished
    int m_count;
    int m_len;
    bit m_hs;
    int m_stat;
    bit m_pulse;
    int m_code;

    function automatic int wait_len(input int idx);
        return (idx == 0) ? 2048 : (1 << (12 + idx));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_count = 0; m_len = 0; m_hs = 1;
            m_stat = 31; m_pulse = 0; m_code = 5;
        end else begin
            m_pulse = 0;
            if (stop_enter) begin
                m_mode = 1; m_count = 0; m_stat = 0;
            end else if (m_mode == 1 && stop_release) begin
                m_mode = 2; m_count = 0; m_len = wait_len(m_code - 1); m_hs = cpu_on_hs;
            end else if (m_mode == 2) begin
                m_count++;
                for (int k = 0; k < 5; k++)
                    if (m_count >= wait_len(k)) m_stat = m_stat | (1 << k);
                if (m_count == m_len) begin
                    m_mode = 3; m_pulse = 1;
                end
            end
            if (reg_wr && !reg_addr && reg_wdata[2:0] >= 1 && reg_wdata[2:0] <= 5)
                m_code = int'(reg_wdata[2:0]);
        end
    end

    task automatic check_val(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // compare every output on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check_val(m_hs ? "R8 clk_ready" : "R9 clk_ready", int'(clk_ready),
                      int'(m_mode == 0 || m_mode == 3 || (m_mode == 2 && !m_hs)));
            check_val("R3 settle_pulse", int'(settle_pulse), int'(m_pulse));
            if (reg_addr) check_val("R5 status read", int'(reg_rdata), m_stat);
            else          check_val("R1 select read", int'(reg_rdata), m_code);
        end
    end

    task automatic report;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<190000 cycles", cycles);
            report();
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic a, input logic [7:0] d);
        @(posedge clk); #2;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(posedge clk); #2;
        reg_addr = a;
        @(negedge clk);
        v = reg_rdata;
    endtask

    task automatic do_stop;
        @(posedge clk); #2; stop_enter = 1'b1;
        @(posedge clk); #2; stop_enter = 1'b0;
    endtask

    task automatic release_timed(input bit hs, input int exp_len, input string tag);
        int n = 0;
        @(posedge clk); #2; stop_release = 1'b1; cpu_on_hs = hs;
        @(posedge clk); #2; stop_release = 1'b0;
        while (n < 70000) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (n == 10)
                check_val(hs ? "R8 ready low in wait" : "R9 ready high in wait",
                          int'(clk_ready), hs ? 0 : 1);
            if (settle_pulse) break;
        end
        check_val(tag, n, exp_len);
        check_val("R8 ready with pulse", int'(clk_ready), 1);
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        rd(1'b0, v); check_val("R1 reset select", int'(v), 8'h05);
        rd(1'b1, v); check_val("R10 reset status", int'(v), 8'h1F);
        check_val("R10 reset ready", int'(clk_ready), 1);

        wr(1'b0, 8'h00); rd(1'b0, v); check_val("R2 code 000 ignored", int'(v), 8'h05);
        wr(1'b0, 8'h06); rd(1'b0, v); check_val("R2 code 110 ignored", int'(v), 8'h05);
        wr(1'b0, 8'h07); rd(1'b0, v); check_val("R2 code 111 ignored", int'(v), 8'h05);
        wr(1'b0, 8'hF9); rd(1'b0, v); check_val("R2 upper bits dropped", int'(v), 8'h01);
        wr(1'b1, 8'h00); rd(1'b1, v); check_val("R5 status write ignored", int'(v), 8'h1F);

        // 2^11 wait from the high-speed clock
        do_stop();
        rd(1'b1, v); check_val("R7 status cleared", int'(v), 8'h00);
        check_val("R7 ready dropped", int'(clk_ready), 0);
        repeat (20) @(posedge clk);
        rd(1'b1, v); check_val("R7 held while stopped", int'(v), 8'h00);
        release_timed(1'b1, 2048, "R3 wait 2^11");
        rd(1'b1, v); check_val("R6 longer bits clear", int'(v), 8'h01);

        // release outside stop is ignored
        @(posedge clk); #2; stop_release = 1'b1;
        @(posedge clk); #2; stop_release = 1'b0;
        repeat (5) @(negedge clk) check_val("R11 no pulse", int'(settle_pulse), 0);
        rd(1'b1, v); check_val("R11 status unchanged", int'(v), 8'h01);

        // 2^13 wait on the ring oscillator, select rewritten mid-wait
        wr(1'b0, 8'h02);
        do_stop();
        fork
            release_timed(1'b0, 8192, "R4 latched 2^13 wait");
            begin
                repeat (100) @(posedge clk);
                #2; reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h01;
                @(posedge clk); #2; reg_wr = 1'b0;
            end
        join
        rd(1'b1, v); check_val("R9 status advanced", int'(v), 8'h03);
        rd(1'b0, v); check_val("R4 new code stored", int'(v), 8'h01);

        // 2^14 wait, high-speed
        wr(1'b0, 8'h03);
        do_stop();
        release_timed(1'b1, 16384, "R3 wait 2^14");
        rd(1'b1, v); check_val("R6 after 2^14", int'(v), 8'h07);

        // stop wins over a simultaneous release, then 2^16 wait
        wr(1'b0, 8'h05);
        do_stop();
        @(posedge clk); #2; stop_enter = 1'b1; stop_release = 1'b1;
        @(posedge clk); #2; stop_enter = 1'b0; stop_release = 1'b0;
        @(negedge clk); check_val("R7 stop over release", int'(clk_ready), 0);
        release_timed(1'b1, 65536, "R3 wait 2^16");
        rd(1'b1, v); check_val("R5 all bits after 2^16", int'(v), 8'h1F);

        repeat (4) @(posedge clk);
        report();
    end

endmodule